// File: doc/BRIEF.md
# Dual-Clock Single-Bit FIFO with Programmable Thresholds

This block is a first-in first-out store for a serial bit stream, one bit wide and 64 entries deep. Data enters on a write clock and leaves on a read clock. The two clocks may be the same net, or they may run with no fixed relation to each other. Pointers cross between the clock domains in Gray code through two-flop synchronisers. Each flag is computed in the domain that acts on it: empty and almost-empty in the read domain, full and almost-full in the write domain.

A write needs two enables in agreement: `wr_en` high and `wr_en_n` low. While `ofs_load` is high, the write port loads a threshold from `ofs_val` instead of storing data. Loads go to the almost-empty threshold first, then the almost-full threshold, and keep alternating. The read port has a registered output bit. It also has an output-enable input, which is mirrored onto a drive-enable output so that a pad or a bus multiplexer above the block can tri-state the bit.

Both thresholds are quasi-static. They are meant to be loaded while the read side is idle, because the almost-empty threshold is used in the read domain without a synchroniser.

Top module: `sfifo_serial`

## Requirements
- R1: On a rising `wr_clk` edge, `wr_bit` is stored only when `wr_en` is 1, `wr_en_n` is 0, `ofs_load` is 0 and the FIFO is not full. Any other combination of the two enables stores nothing.
- R2: On a rising `rd_clk` edge with `rd_en` 1 and the FIFO not empty, the oldest stored bit appears on `rd_bit` after that edge. Otherwise `rd_bit` holds its value.
- R3: A write attempted while `full` is 1 is dropped: no bit is stored and the write pointer does not move.
- R4: A read attempted while `empty` is 1 is dropped: `rd_bit` and the read pointer stay unchanged.
- R5: Once the write pointer has crossed into the read domain, `empty` is 1 exactly when zero bits are stored.
- R6: Once the read pointer has crossed into the write domain, `full` is 1 exactly when 64 bits are stored.
- R7: `almost_empty` is 1 when the stored count is less than or equal to the almost-empty threshold. `almost_full` is 1 when the free space (64 minus count) is less than or equal to the almost-full threshold. Both thresholds are 7 after reset.
- R8: A `wr_clk` edge with `ofs_load` 1 copies the 8-bit `ofs_val` into a threshold and stores no data. The first load after reset sets the almost-empty threshold, the second sets the almost-full threshold, and the target alternates after that.
- R9: `rd_drive` equals `out_en`. When it is 0, `rd_bit` is to be treated as undriven.
- R10: With `rst_n` low on a clock edge (synchronous, active-low), that domain clears its pointer, synchroniser, output bit and threshold state. After reset: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `rd_bit`=0, both thresholds 7, and the next load targets the almost-empty threshold.
- R11: Data order and flags are correct both with `rd_clk` tied to `wr_clk` and with independent clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, applied to both domains |
| wr_bit | input | 1 | Data bit to store |
| wr_en | input | 1 | Active-high write qualifier |
| wr_en_n | input | 1 | Active-low write qualifier |
| ofs_load | input | 1 | Threshold load strobe (write domain) |
| ofs_val | input | 8 | Threshold value to load |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output enable for the data bit |
| rd_bit | output | 1 | Registered read data |
| rd_drive | output | 1 | Drive enable for `rd_bit` |
| empty | output | 1 | No bits stored (read domain) |
| almost_empty | output | 1 | Count at or below almost-empty threshold (read domain) |
| full | output | 1 | 64 bits stored (write domain) |
| almost_full | output | 1 | Free space at or below almost-full threshold (write domain) |

## Verification
Some internal faults show at the ports at once. A wrong write pointer or memory address shows up in the first bits read back, because the order of those bits no longer matches the order written. A pointer that wraps past the other shows up as soon as an over-full or over-empty sequence is read out: the bits come out duplicated or lost.

Other faults appear a little later. A bad synchroniser, or a bad Gray or binary conversion, shows as a flag that is wrong two or three cycles of the observing clock after the other side moves. Threshold state that is wrong, or a load target that does not alternate, shows when the count is driven to the boundary either side of a loaded value.

// File: rtl/sfifo_pkg.sv
// Package: shared types and defaults for the serial FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sfifo_pkg;

    // Which threshold the next load strobe writes.
    typedef enum logic {
        LD_AEMPTY = 1'b0,
        LD_AFULL  = 1'b1
    } ld_tgt_e;

    localparam int OFS_W_DEF   = 8;
    localparam int OFS_RST_DEF = 7;

endpackage

// File: rtl/sfifo_sync.sv
// Module: two-flop synchroniser for a Gray-coded pointer.
// Assumes: the input changes at most one bit per source clock (Gray code),
// so a sampled value is always either the old or the new pointer.
module sfifo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two capture stages in the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/sfifo_wr_side.sv
// Module: write-domain control. Holds the write pointer and the threshold
// registers, and computes full / almost-full from the synchronised read pointer.
// Assumes: rgray_s is already synchronised into the write clock domain.
module sfifo_wr_side
    import sfifo_pkg::*;
#(
    parameter int AW      = 6,
    parameter int OFS_W   = OFS_W_DEF,
    parameter int OFS_RST = OFS_RST_DEF,
    localparam int PW     = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_en_n,
    input  logic             ofs_load,
    input  logic [OFS_W-1:0] ofs_val,
    input  logic [PW-1:0]    rgray_s,
    output logic [PW-1:0]    wptr,
    output logic [PW-1:0]    wgray,
    output logic             mem_we,
    output logic             full,
    output logic             almost_full,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);

    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wnext;
    ld_tgt_e       ld_tgt;

    // Convert the synchronised Gray read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign wcount      = wptr - rbin_s;
    assign wnext       = wptr + 1'b1;
    assign full        = (wcount == PW'(DEPTH));
    assign almost_full = (DEPTH - int'(wcount)) <= int'(af_ofs);
    assign mem_we      = wr_en & ~wr_en_n & ~ofs_load & ~full;

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // Load the thresholds, alternating the target on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs <= OFS_W'(OFS_RST);
            af_ofs <= OFS_W'(OFS_RST);
            ld_tgt <= LD_AEMPTY;
        end else if (ofs_load) begin
            if (ld_tgt == LD_AEMPTY) begin
                ae_ofs <= ofs_val;
                ld_tgt <= LD_AFULL;
            end else begin
                af_ofs <= ofs_val;
                ld_tgt <= LD_AEMPTY;
            end
        end
    end

endmodule

// File: rtl/sfifo_rd_side.sv
// Module: read-domain control. Holds the read pointer and the registered
// output bit, and computes empty / almost-empty from the synchronised write
// pointer.
// Assumes: wgray_s is synchronised into the read domain; ae_ofs is
// quasi-static (changed only while the read side is idle).
module sfifo_rd_side #(
    parameter int AW    = 6,
    parameter int OFS_W = 8,
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             mem_q,
    input  logic [PW-1:0]    wgray_s,
    input  logic [OFS_W-1:0] ae_ofs,
    output logic [PW-1:0]    rptr,
    output logic [PW-1:0]    rgray,
    output logic             rd_bit,
    output logic             empty,
    output logic             almost_empty
);

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rnext;
    logic          rd_go;

    // Convert the synchronised Gray write pointer back to binary.
    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign rcount       = wbin_s - rptr;
    assign rnext        = rptr + 1'b1;
    assign empty        = (rcount == '0);
    assign almost_empty = int'(rcount) <= int'(ae_ofs);
    assign rd_go        = rd_en & ~empty;

    // Advance the read pointers and register the outgoing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            rgray  <= '0;
            rd_bit <= 1'b0;
        end else if (rd_go) begin
            rptr   <= rnext;
            rgray  <= rnext ^ (rnext >> 1);
            rd_bit <= mem_q;
        end
    end

endmodule

// File: rtl/sfifo_serial.sv
// Module: top of the dual-clock single-bit FIFO. Holds the storage array and
// joins the write side, the read side and the two pointer synchronisers.
// Assumes: rst_n is held low for at least one edge of each clock.
module sfifo_serial #(
    parameter int AW      = 6,
    parameter int OFS_W   = 8,
    parameter int OFS_RST = 7
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_bit,
    input  logic             wr_en,
    input  logic             wr_en_n,
    input  logic             ofs_load,
    input  logic [OFS_W-1:0] ofs_val,
    input  logic             rd_en,
    input  logic             out_en,
    output logic             rd_bit,
    output logic             rd_drive,
    output logic             empty,
    output logic             almost_empty,
    output logic             full,
    output logic             almost_full
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DEPTH-1:0] mem;
    logic [PW-1:0]    wr_ptr, wr_gray, wr_gray_s;
    logic [PW-1:0]    rd_ptr, rd_gray, rd_gray_s;
    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic             mem_we;
    logic             mem_q;

    // Store the incoming bit at the write address.
    always_ff @(posedge wr_clk) begin
        if (mem_we) begin
            mem[wr_ptr[AW-1:0]] <= wr_bit;
        end
    end

    assign mem_q    = mem[rd_ptr[AW-1:0]];
    assign rd_drive = out_en;

    sfifo_wr_side #(.AW(AW), .OFS_W(OFS_W), .OFS_RST(OFS_RST)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_en_n     (wr_en_n),
        .ofs_load    (ofs_load),
        .ofs_val     (ofs_val),
        .rgray_s     (rd_gray_s),
        .wptr        (wr_ptr),
        .wgray       (wr_gray),
        .mem_we      (mem_we),
        .full        (full),
        .almost_full (almost_full),
        .ae_ofs      (ae_ofs),
        .af_ofs      (af_ofs)
    );

    sfifo_rd_side #(.AW(AW), .OFS_W(OFS_W)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .mem_q        (mem_q),
        .wgray_s      (wr_gray_s),
        .ae_ofs       (ae_ofs),
        .rptr         (rd_ptr),
        .rgray        (rd_gray),
        .rd_bit       (rd_bit),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    sfifo_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    sfifo_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

endmodule

// File: rtl/sfifo_serial_chk.sv
// Module: assertion checker for sfifo_serial, attached by bind.
// Assumes: connected to the top-level pointers and ports named below.
module sfifo_serial_chk #(
    parameter int PW = 7
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_en_n,
    input logic          ofs_load,
    input logic          rd_en,
    input logic          rd_bit,
    input logic          empty,
    input logic          almost_empty,
    input logic          full,
    input logic          almost_full,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr
);

    // R3: a write attempted while full leaves the write pointer in place.
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en && !wr_en_n) |=> $stable(wr_ptr));

    // R4: a read attempted while empty changes neither pointer nor data.
    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en) |=> ($stable(rd_ptr) && $stable(rd_bit)));

    // R1: without both enables in agreement, nothing is stored.
    p_needs_both_en_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(wr_en && !wr_en_n) |=> $stable(wr_ptr));

    // R8: a load cycle stores no data.
    p_load_no_write_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ofs_load |=> $stable(wr_ptr));

    // R7: full always implies almost-full.
    p_full_af_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

    // R7: empty always implies almost-empty.
    p_empty_ae_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    // R10: reset leaves the read side empty and the write side not full.
    p_reset_empty_r10: assert property (@(posedge rd_clk)
        !rst_n |=> (empty && almost_empty));
    p_reset_notfull_r10: assert property (@(posedge wr_clk)
        !rst_n |=> (!full && !almost_full));

endmodule

bind sfifo_serial sfifo_serial_chk #(.PW(AW + 1)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_en_n      (wr_en_n),
    .ofs_load     (ofs_load),
    .rd_en        (rd_en),
    .rd_bit       (rd_bit),
    .empty        (empty),
    .almost_empty (almost_empty),
    .full         (full),
    .almost_full  (almost_full),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr)
);

// File: tb/sfifo_serial_test.sv
`timescale 1ns/1ps
module sfifo_serial_test;

    logic       wclk = 1'b0, aclk = 1'b0, async_mode = 1'b0;
    logic       rclk;
    logic       rst_n = 1'b0;
    logic       wr_bit = 1'b0, wr_en = 1'b0, wr_en_n = 1'b1, ofs_load = 1'b0;
    logic [7:0] ofs_val = '0;
    logic       rd_en = 1'b0, out_en = 1'b1;
    logic       rd_bit, rd_drive, empty, almost_empty, full, almost_full;

    int n_chk = 0, n_bad = 0, cyc = 0, seq = 0;
    logic mq [64];
    int   mhead = 0, mcnt = 0;
    logic last_bit = 1'b0;

    always #2   wclk = ~wclk;   // 250 MHz
    always #3.5 aclk = ~aclk;   // unrelated read clock for R11
    assign rclk = async_mode ? aclk : wclk;

    sfifo_serial uut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n),
        .wr_bit(wr_bit), .wr_en(wr_en), .wr_en_n(wr_en_n),
        .ofs_load(ofs_load), .ofs_val(ofs_val),
        .rd_en(rd_en), .out_en(out_en),
        .rd_bit(rd_bit), .rd_drive(rd_drive),
        .empty(empty), .almost_empty(almost_empty),
        .full(full), .almost_full(almost_full)
    );

    // op: 0 write n bits, 1 read n bits; flags expected after settling: E F AE AF
    localparam logic [15:0] VEC [9] = '{
        {2'd0, 8'd5,  2'b00, 4'b0010},
        {2'd0, 8'd3,  2'b00, 4'b0000},
        {2'd1, 8'd2,  2'b00, 4'b0010},
        {2'd0, 8'd51, 2'b00, 4'b0001},
        {2'd0, 8'd6,  2'b00, 4'b0001},
        {2'd0, 8'd1,  2'b00, 4'b0101},
        {2'd0, 8'd3,  2'b00, 4'b0101},
        {2'd1, 8'd64, 2'b00, 4'b1010},
        {2'd1, 8'd2,  2'b00, 4'b1010}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic [3:0] f);
        chk({tag, " R5 empty"},        empty,        f[3]);
        chk({tag, " R6 full"},         full,         f[2]);
        chk({tag, " R7 almost_empty"}, almost_empty, f[1]);
        chk({tag, " R7 almost_full"},  almost_full,  f[0]);
    endtask

    task automatic settle();
        repeat (10) @(negedge wclk);
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 1'b0;
        repeat (8) @(negedge wclk);
        mhead = 0; mcnt = 0; last_bit = 1'b0;
        rst_n = 1'b1;
        settle();
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en = 1'b1; wr_en_n = 1'b0;
            wr_bit = seq[0] ^ seq[2] ^ seq[5];
            if (mcnt < 64) begin
                mq[(mhead + mcnt) % 64] = wr_bit;
                mcnt++;
            end
            seq++;
        end
        @(negedge wclk);
        wr_en = 1'b0; wr_en_n = 1'b1;
    endtask

    task automatic rd_n(input int n, input string tag);
        logic exp_b = 1'b0;
        logic was_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            if (i > 0) begin
                chk(was_valid ? {tag, " R2 data"} : {tag, " R4 hold"}, rd_bit, exp_b);
                last_bit = exp_b;
            end
            rd_en = 1'b1;
            was_valid = (mcnt > 0);
            if (was_valid) begin
                exp_b = mq[mhead];
                mhead = (mhead + 1) % 64;
                mcnt--;
            end else begin
                exp_b = last_bit;
            end
        end
        @(negedge rclk);
        rd_en = 1'b0;
        if (n > 0) begin
            chk(was_valid ? {tag, " R2 data"} : {tag, " R4 hold"}, rd_bit, exp_b);
            last_bit = exp_b;
        end
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge wclk);
        ofs_load = 1'b1; ofs_val = v;
        @(negedge wclk);
        ofs_load = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge wclk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk_flags("R10 reset", 4'b1010);
        chk("R10 rd_bit reset", rd_bit, 1'b0);
        // R9: drive enable follows out_en
        chk("R9 drive on", rd_drive, 1'b1);
        @(negedge wclk); out_en = 1'b0; #0.5;
        chk("R9 drive off", rd_drive, 1'b0);
        out_en = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 9; k++) begin
            if (VEC[k][15:14] == 2'd0) wr_n(int'(VEC[k][13:6]));
            else                       rd_n(int'(VEC[k][13:6]), "vec");
            settle();
            chk_flags($sformatf("vec%0d", k), VEC[k][3:0]);
        end

        // R1: a single enable alone stores nothing
        @(negedge wclk); wr_en = 1'b1; wr_en_n = 1'b1; wr_bit = 1'b1;
        repeat (3) @(negedge wclk);
        wr_en = 1'b0; wr_en_n = 1'b0;
        repeat (3) @(negedge wclk);
        wr_en_n = 1'b1;
        settle();
        chk("R1 single enable ignored", empty, 1'b1);

        // R8: loads with write enables active store no data
        @(negedge wclk);
        ofs_load = 1'b1; wr_en = 1'b1; wr_en_n = 1'b0; wr_bit = 1'b1; ofs_val = 8'd10;
        @(negedge wclk); ofs_val = 8'd3;
        @(negedge wclk); ofs_load = 1'b0; wr_en = 1'b0; wr_en_n = 1'b1;
        settle();
        chk("R8 load stores no data", empty, 1'b1);
        wr_n(10); settle();
        chk("R8 ae ofs=10 at count 10", almost_empty, 1'b1);
        wr_n(1); settle();
        chk("R8 ae ofs=10 at count 11", almost_empty, 1'b0);
        wr_n(50); settle();
        chk("R8 af ofs=3 at free 3", almost_full, 1'b1);
        rd_n(1, "R8"); settle();
        chk("R8 af ofs=3 at free 4", almost_full, 1'b0);
        wr_n(1); settle();
        chk("R8 af ofs=3 back at free 3", almost_full, 1'b1);
        load(8'd70); settle();
        chk("R8 third load targets ae", almost_empty, 1'b1);
        chk("R8 third load leaves af", almost_full, 1'b1);

        // R10: reset restores thresholds and load target
        wr_n(2);
        do_reset();
        chk_flags("R10 after reload", 4'b1010);
        wr_n(7); settle();
        chk("R10 default ae at count 7", almost_empty, 1'b1);
        wr_n(1); settle();
        chk("R10 default ae at count 8", almost_empty, 1'b0);
        load(8'd20); settle();
        chk("R10 first load goes to ae", almost_empty, 1'b1);
        chk("R10 af untouched", almost_full, 1'b0);
        rd_n(8, "R10"); settle();
        chk_flags("R10 drained", 4'b1010);

        // R11: independent read clock
        async_mode = 1'b1;
        do_reset();
        chk_flags("R11 async reset", 4'b1010);
        wr_n(20); settle();
        chk("R11 async not empty", empty, 1'b0);
        chk("R11 async ae clear", almost_empty, 1'b0);
        rd_n(20, "R11"); settle();
        chk_flags("R11 async drained", 4'b1010);
        wr_n(64); settle();
        chk("R11 async full", full, 1'b1);
        rd_n(64, "R11"); settle();
        chk_flags("R11 async drained again", 4'b1010);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule